// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Duplicate Guard

This block is a fully associative address translation cache of sixteen entries. Each entry holds a virtual tag that covers an even/odd pair of pages. It also holds an address space identifier, a global flag, a compressed page-size mask, and two physical halves. Each half carries a frame number, a cache attribute, a dirty (writable) flag and a valid flag.

A combinational lookup port takes a 32-bit virtual address, the current address space identifier and a store flag. It returns the physical address, the cache attribute and a status code in the same cycle. Software-style maintenance uses three further ports:

- an indexed write,
- a registered probe that reports the matching slot or a probe-failure bit,
- a combinational read that returns any slot in its external format.

Every write is compared against all other initialised entries before it commits. A write that would create two entries matching the same address and identifier is dropped. It raises a one-cycle machine-check pulse and sets a sticky shutdown flag. While that flag is set, no lookup and no probe can match, and only a reset clears it. A hidden per-slot initialised bit, cleared by reset and set by a committed write, keeps unwritten slots out of both matching and duplicate detection.

Top module: `pair_tlb`

## Requirements
- R1: After reset every slot is uninitialised and reads back as all zero; `ts`, `mchk`, `pr_miss` and `pr_idx` are 0, and every lookup reports refill.
- R2: A slot matches when it is initialised, its tag equals VA[31:13] on every bit not covered by the page mask, and its identifier equals the current one unless the slot is global. The slot is global only when bit 0 of both written low words is 1.
- R3: The 12-bit write mask is stored as 6 bits, one per bit pair, set when either bit of the pair is 1. The page mask reads back with both bits of each pair equal to the stored bit. Masks 0, 0x003, 0x00F, 0x03F, 0x0FF, 0x3FF and 0xFFF give 4K to 16M pages.
- R4: With n stored mask bits set, VA[12+2n] selects the odd half (1) or the even half (0). The physical address takes its lower 12+2n bits from the VA and the remaining upper bits from the selected frame number shifted left by 12.
- R5: `lk_status` is 1 (refill) on no match, 2 (invalid) on a match whose selected half has V=0, 3 (modified) on a store to a valid half with D=0, and 0 (hit) otherwise. `lk_pa` and `lk_attr` are zero unless the status is hit.
- R6: A low word is laid out as frame number in [25:6], cache attribute in [5:3], D in [2], V in [1] and G in [0]. The attribute is passed unchanged to `lk_attr`, where value 2 means uncached.
- R7: A write whose tag, under the union of both masks, equals that of another initialised slot with the same identifier (or where either side is global) does not commit. It drives `mchk` high for exactly the next cycle and sets `ts`.
- R8: Once set, `ts` stays 1 until reset. While it is set, every lookup reports refill and every probe reports failure.
- R9: The initialised bit of a slot rises only on a committed write to it. Uninitialised slots never match and never count as duplicates. Rewriting a slot with its own tag is not a duplicate.
- R10: A probe updates `pr_miss` and `pr_idx` at the next clock edge: on a match, `pr_miss`=0 and `pr_idx` is the lowest matching slot; otherwise `pr_miss`=1 and `pr_idx`=0.
- R11: A write with `wr_index` of 16 or more changes no slot and raises neither `mchk` nor `ts`.
- R12: The read port returns the slot's expanded mask, tag, identifier and both low words, with bit 0 of each low word equal to the slot's global flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address space identifier |
| lk_store | input | 1 | Lookup is a store |
| lk_pa | output | 32 | Translated physical address (zero unless hit) |
| lk_attr | output | 3 | Cache attribute of the hit (zero unless hit) |
| lk_status | output | 2 | 0 hit, 1 refill, 2 invalid, 3 modified |
| wr_en | input | 1 | Indexed write strobe |
| wr_index | input | 5 | Target slot of the write |
| wr_mask | input | 12 | Page mask to write |
| wr_vpn2 | input | 19 | Tag to write (VA[31:13]) |
| wr_asid | input | 8 | Identifier to write |
| wr_lo0 | input | 26 | Even half low word |
| wr_lo1 | input | 26 | Odd half low word |
| pr_en | input | 1 | Probe strobe |
| pr_vpn2 | input | 19 | Probe tag |
| pr_asid | input | 8 | Probe identifier |
| pr_miss | output | 1 | Last probe failed |
| pr_idx | output | 4 | Slot found by the last probe |
| rd_index | input | 4 | Read slot |
| rd_mask | output | 12 | Expanded page mask of the read slot |
| rd_vpn2 | output | 19 | Tag of the read slot |
| rd_asid | output | 8 | Identifier of the read slot |
| rd_lo0 | output | 26 | Even half low word of the read slot |
| rd_lo1 | output | 26 | Odd half low word of the read slot |
| mchk | output | 1 | One-cycle machine-check pulse after a duplicate write |
| ts | output | 1 | Sticky shutdown flag |

## Verification
The bound checker watches, on every cycle, the behaviours of the shutdown and duplicate path:

- `ts` is sticky and forces refill and probe failure.
- A detected duplicate leaves every initialised bit unchanged and is followed by `mchk` and `ts`.
- Initialised bits only rise.
- Out-of-range writes touch nothing.
- Non-hit lookups drive zero address and attribute.

Only the bench's scenarios can show the arithmetic of translation: the masked tag compare, the odd/even select bit, the composed physical address, global and identifier filtering, mask compression, and which slot a probe reports. For these it sweeps every slot through every page size, both halves, load and store, and matching and foreign identifiers.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;
  localparam int VA_W     = 32;
  localparam int PG_SHIFT = 12;
  localparam int VPN2_W   = VA_W - PG_SHIFT - 1;
  localparam int PFN_W    = VA_W - PG_SHIFT;
  localparam int MASK_W   = 12;
  localparam int CMASK_W  = MASK_W / 2;
  localparam int ATTR_W   = 3;
  localparam int LO_W     = PFN_W + ATTR_W + 3;
  localparam int VPAGE_W  = VA_W - PG_SHIFT;

  typedef enum logic [1:0] {
    LK_HIT      = 2'd0,
    LK_REFILL   = 2'd1,
    LK_INVALID  = 2'd2,
    LK_MODIFIED = 2'd3
  } lk_status_e;

  typedef struct packed {
    logic [PFN_W-1:0]  pfn;
    logic [ATTR_W-1:0] attr;
    logic              dirty;
    logic              valid;
  } half_t;

  // One stored bit per mask pair: set if either bit of the pair is set.
  function automatic logic [CMASK_W-1:0] mask_pack(input logic [MASK_W-1:0] m);
    logic [CMASK_W-1:0] c;
    for (int k = 0; k < CMASK_W; k++) c[k] = m[2*k] | m[2*k+1];
    return c;
  endfunction

  function automatic logic [MASK_W-1:0] mask_unpack(input logic [CMASK_W-1:0] c);
    logic [MASK_W-1:0] m;
    for (int k = 0; k < CMASK_W; k++) begin
      m[2*k]   = c[k];
      m[2*k+1] = c[k];
    end
    return m;
  endfunction

  // Tag compare with the masked tag bits treated as don't-care.
  function automatic logic tag_equal(input logic [VPN2_W-1:0] a,
                                     input logic [VPN2_W-1:0] b,
                                     input logic [MASK_W-1:0] ignore);
    logic [VPN2_W-1:0] care;
    care = ~{{(VPN2_W-MASK_W){1'b0}}, ignore};
    return ((a ^ b) & care) == '0;
  endfunction

  // vp is VA[31:12]; the highest set pair moves the select bit up by two.
  function automatic logic odd_pick(input logic [VPAGE_W-1:0] vp,
                                    input logic [CMASK_W-1:0] c);
    logic s;
    s = vp[0];
    for (int k = 0; k < CMASK_W; k++) if (c[k]) s = vp[2+2*k];
    return s;
  endfunction

  function automatic logic [VA_W-1:0] pa_build(input logic [PFN_W-1:0] pfn,
                                               input logic [CMASK_W-1:0] c,
                                               input logic [VA_W-1:0] va);
    logic [PFN_W-1:0] from_va;
    from_va = {{(PFN_W-MASK_W){1'b0}}, mask_unpack(c)};
    return {(pfn & ~from_va) | (va[VA_W-1:PG_SHIFT] & from_va), va[PG_SHIFT-1:0]};
  endfunction

  function automatic logic [LO_W-1:0] lo_encode(input half_t h, input logic g);
    return {h.pfn, h.attr, h.dirty, h.valid, g};
  endfunction
endpackage

// File: rtl/pair_tlb_entry.sv
module pair_tlb_entry
  import pair_tlb_pkg::*;
#(
  parameter int ASID_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               is_target,
  input  logic [VPN2_W-1:0]  w_vpn2,
  input  logic [ASID_W-1:0]  w_asid,
  input  logic               w_g,
  input  logic [CMASK_W-1:0] w_cmask,
  input  half_t              w_even,
  input  half_t              w_odd,
  input  logic [VPAGE_W-1:0] lk_vpage,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic [VPN2_W-1:0]  pr_vpn2,
  input  logic [ASID_W-1:0]  pr_asid,
  output logic               lk_match,
  output half_t              lk_half,
  output logic               pr_match,
  output logic               dup,
  output logic               q_init,
  output logic [VPN2_W-1:0]  q_vpn2,
  output logic [ASID_W-1:0]  q_asid,
  output logic               q_g,
  output logic [CMASK_W-1:0] q_cmask,
  output half_t              q_even,
  output half_t              q_odd
);
  logic [MASK_W-1:0] own_mask;
  logic [MASK_W-1:0] union_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_init  <= 1'b0;
      q_vpn2  <= '0;
      q_asid  <= '0;
      q_g     <= 1'b0;
      q_cmask <= '0;
      q_even  <= '0;
      q_odd   <= '0;
    end else if (we) begin
      q_init  <= 1'b1;
      q_vpn2  <= w_vpn2;
      q_asid  <= w_asid;
      q_g     <= w_g;
      q_cmask <= w_cmask;
      q_even  <= w_even;
      q_odd   <= w_odd;
    end
  end

  assign own_mask   = mask_unpack(q_cmask);
  assign union_mask = own_mask | mask_unpack(w_cmask);

  always_comb begin
    lk_match = q_init
             && tag_equal(q_vpn2, lk_vpage[VPAGE_W-1:1], own_mask)
             && (q_g || (q_asid == lk_asid));
    lk_half  = odd_pick(lk_vpage, q_cmask) ? q_odd : q_even;
    pr_match = q_init
             && tag_equal(q_vpn2, pr_vpn2, own_mask)
             && (q_g || (q_asid == pr_asid));
    dup      = q_init && !is_target
             && tag_equal(q_vpn2, w_vpn2, union_mask)
             && (q_g || w_g || (q_asid == w_asid));
  end
endmodule

// File: rtl/pair_tlb_pick.sv
module pair_tlb_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) idx = IW'(k);
    end
  end
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [VA_W-1:0]     lk_va,
  input  logic [ASID_W-1:0]   lk_asid,
  input  logic                lk_store,
  output logic [VA_W-1:0]     lk_pa,
  output logic [ATTR_W-1:0]   lk_attr,
  output logic [1:0]          lk_status,
  input  logic                wr_en,
  input  logic [IDX_W:0]      wr_index,
  input  logic [MASK_W-1:0]   wr_mask,
  input  logic [VPN2_W-1:0]   wr_vpn2,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic [LO_W-1:0]     wr_lo0,
  input  logic [LO_W-1:0]     wr_lo1,
  input  logic                pr_en,
  input  logic [VPN2_W-1:0]   pr_vpn2,
  input  logic [ASID_W-1:0]   pr_asid,
  output logic                pr_miss,
  output logic [IDX_W-1:0]    pr_idx,
  input  logic [IDX_W-1:0]    rd_index,
  output logic [MASK_W-1:0]   rd_mask,
  output logic [VPN2_W-1:0]   rd_vpn2,
  output logic [ASID_W-1:0]   rd_asid,
  output logic [LO_W-1:0]     rd_lo0,
  output logic [LO_W-1:0]     rd_lo1,
  output logic                mchk,
  output logic                ts
);
  localparam logic [IDX_W:0] ENT_L = ENTRIES[IDX_W:0];

  // Named internal events, also used by the bound checker.
  logic               wr_in_range;
  logic               dup_evt;
  logic               wr_ok;
  logic [ENTRIES-1:0] dup_vec;
  logic [ENTRIES-1:0] init_vec;
  logic [ENTRIES-1:0] lk_vec;
  logic [ENTRIES-1:0] pr_vec;

  half_t              w_even, w_odd;
  logic               w_g;
  logic [CMASK_W-1:0] w_cmask;

  half_t              lk_half_arr [ENTRIES];
  logic [VPN2_W-1:0]  q_vpn2      [ENTRIES];
  logic [ASID_W-1:0]  q_asid      [ENTRIES];
  logic               q_g         [ENTRIES];
  logic [CMASK_W-1:0] q_cmask     [ENTRIES];
  half_t              q_even      [ENTRIES];
  half_t              q_odd       [ENTRIES];

  logic               lk_found, pr_found;
  logic [IDX_W-1:0]   lk_sel, pr_sel;
  half_t              lk_h;

  assign w_even  = half_t'(wr_lo0[LO_W-1:1]);
  assign w_odd   = half_t'(wr_lo1[LO_W-1:1]);
  assign w_g     = wr_lo0[0] & wr_lo1[0];
  assign w_cmask = mask_pack(wr_mask);

  assign wr_in_range = wr_index < ENT_L;
  assign dup_evt     = wr_en && wr_in_range && (|dup_vec);
  assign wr_ok       = wr_en && wr_in_range && !(|dup_vec);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic lk_m, pr_m;
    pair_tlb_entry #(.ASID_W(ASID_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (wr_ok && (wr_index == (IDX_W+1)'(i))),
      .is_target (wr_index == (IDX_W+1)'(i)),
      .w_vpn2    (wr_vpn2),
      .w_asid    (wr_asid),
      .w_g       (w_g),
      .w_cmask   (w_cmask),
      .w_even    (w_even),
      .w_odd     (w_odd),
      .lk_vpage  (lk_va[VA_W-1:PG_SHIFT]),
      .lk_asid   (lk_asid),
      .pr_vpn2   (pr_vpn2),
      .pr_asid   (pr_asid),
      .lk_match  (lk_m),
      .lk_half   (lk_half_arr[i]),
      .pr_match  (pr_m),
      .dup       (dup_vec[i]),
      .q_init    (init_vec[i]),
      .q_vpn2    (q_vpn2[i]),
      .q_asid    (q_asid[i]),
      .q_g       (q_g[i]),
      .q_cmask   (q_cmask[i]),
      .q_even    (q_even[i]),
      .q_odd     (q_odd[i])
    );
    // Shutdown blocks every match.
    assign lk_vec[i] = lk_m && !ts;
    assign pr_vec[i] = pr_m && !ts;
  end

  pair_tlb_pick #(.N(ENTRIES), .IW(IDX_W)) u_lk_pick (
    .req   (lk_vec),
    .found (lk_found),
    .idx   (lk_sel)
  );

  pair_tlb_pick #(.N(ENTRIES), .IW(IDX_W)) u_pr_pick (
    .req   (pr_vec),
    .found (pr_found),
    .idx   (pr_sel)
  );

  assign lk_h = lk_half_arr[lk_sel];

  always_comb begin
    lk_pa   = '0;
    lk_attr = '0;
    if (!lk_found) begin
      lk_status = LK_REFILL;
    end else if (!lk_h.valid) begin
      lk_status = LK_INVALID;
    end else if (lk_store && !lk_h.dirty) begin
      lk_status = LK_MODIFIED;
    end else begin
      lk_status = LK_HIT;
      lk_pa     = pa_build(lk_h.pfn, q_cmask[lk_sel], lk_va);
      lk_attr   = lk_h.attr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_miss <= 1'b0;
      pr_idx  <= '0;
    end else if (pr_en) begin
      pr_miss <= !pr_found;
      pr_idx  <= pr_found ? pr_sel : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mchk <= 1'b0;
      ts   <= 1'b0;
    end else begin
      mchk <= dup_evt;
      if (dup_evt) ts <= 1'b1;
    end
  end

  always_comb begin
    rd_mask = mask_unpack(q_cmask[rd_index]);
    rd_vpn2 = q_vpn2[rd_index];
    rd_asid = q_asid[rd_index];
    rd_lo0  = lo_encode(q_even[rd_index], q_g[rd_index]);
    rd_lo1  = lo_encode(q_odd[rd_index], q_g[rd_index]);
  end
endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [IDX_W:0]     wr_index,
  input logic               pr_en,
  input logic [31:0]        lk_pa,
  input logic [2:0]         lk_attr,
  input logic [1:0]         lk_status,
  input logic               pr_miss,
  input logic [IDX_W-1:0]   pr_idx,
  input logic               mchk,
  input logic               ts,
  input logic               dup_evt,
  input logic [ENTRIES-1:0] init_vec
);
  localparam logic [IDX_W:0] ENT_L = ENTRIES[IDX_W:0];

  AST_TS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ts |=> ts); // R8
  AST_TS_FORCES_REFILL: assert property (@(posedge clk) disable iff (!rst_n) ts |-> lk_status == 2'd1); // R8
  AST_TS_FAILS_PROBE: assert property (@(posedge clk) disable iff (!rst_n) (ts && pr_en) |=> pr_miss); // R8
  AST_DUP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) dup_evt |=> (mchk && ts)); // R7
  AST_DUP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) dup_evt |=> init_vec == $past(init_vec)); // R7
  AST_MCHK_WITH_TS: assert property (@(posedge clk) disable iff (!rst_n) mchk |-> ts); // R7
  AST_OOR_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_index >= ENT_L) |=> (!mchk && init_vec == $past(init_vec))); // R11
  AST_INIT_ONLY_RISES: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (init_vec & $past(init_vec)) == $past(init_vec)); // R9
  AST_NONHIT_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n) (lk_status != 2'd0) |-> (lk_pa == '0 && lk_attr == '0)); // R5
  AST_PROBE_FAIL_IDX: assert property (@(posedge clk) disable iff (!rst_n) pr_miss |-> pr_idx == '0); // R10
endmodule

bind pair_tlb pair_tlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_index  (wr_index),
  .pr_en     (pr_en),
  .lk_pa     (lk_pa),
  .lk_attr   (lk_attr),
  .lk_status (lk_status),
  .pr_miss   (pr_miss),
  .pr_idx    (pr_idx),
  .mchk      (mchk),
  .ts        (ts),
  .dup_evt   (dup_evt),
  .init_vec  (init_vec)
);

// File: tb/pair_tlb_bench.sv
module pair_tlb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_store = 1'b0;
  logic [31:0] lk_pa;
  logic [2:0]  lk_attr;
  logic [1:0]  lk_status;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_index = '0;
  logic [11:0] wr_mask = '0;
  logic [18:0] wr_vpn2 = '0;
  logic [7:0]  wr_asid = '0;
  logic [25:0] wr_lo0 = '0;
  logic [25:0] wr_lo1 = '0;
  logic        pr_en = 1'b0;
  logic [18:0] pr_vpn2 = '0;
  logic [7:0]  pr_asid = '0;
  logic        pr_miss;
  logic [3:0]  pr_idx;
  logic [3:0]  rd_index = '0;
  logic [11:0] rd_mask;
  logic [18:0] rd_vpn2;
  logic [7:0]  rd_asid;
  logic [25:0] rd_lo0;
  logic [25:0] rd_lo1;
  logic        mchk;
  logic        ts;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Bench model of slot contents.
  int e_n[16], e_vpn2[16], e_asid[16], e_g[16];
  int e_pfn[16][2], e_attr[16][2], e_d[16][2], e_v[16][2];

  pair_tlb u_pair_tlb (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [25:0] mk_lo(int pfn, int attr, int d, int v, int g);
    return 26'((pfn << 6) | (attr << 3) | (d << 2) | (v << 1) | g);
  endfunction

  function automatic logic [31:0] mk_va(int i, int odd);
    int sh = 12 + 2 * e_n[i];
    logic [31:0] low = (32'd1 << sh) - 32'd1;
    return (32'(e_vpn2[i]) << 13) | (32'(odd) << sh) | (32'h005A5A5A & low);
  endfunction

  // {status, attr, pa} expected for slot i.
  function automatic logic [63:0] exp_lookup(int i, logic [31:0] va, int asid, int st);
    int sh = 12 + 2 * e_n[i];
    int h = int'(va[sh]);
    logic [31:0] off = (32'd1 << sh) - 32'd1;
    logic [31:0] pa;
    if (!(e_g[i] != 0 || asid == e_asid[i])) return {27'd0, 2'd1, 3'd0, 32'd0};
    if (e_v[i][h] == 0) return {27'd0, 2'd2, 3'd0, 32'd0};
    if (st != 0 && e_d[i][h] == 0) return {27'd0, 2'd3, 3'd0, 32'd0};
    pa = ((32'(e_pfn[i][h]) << 12) & ~off) | (va & off);
    return {27'd0, 2'd0, 3'(e_attr[i][h]), pa};
  endfunction

  task automatic do_write(input int idx, input logic [11:0] m, input int vpn2, input int asid,
                          input logic [25:0] lo0, input logic [25:0] lo1);
    @(negedge clk);
    wr_en = 1'b1; wr_index = 5'(idx); wr_mask = m; wr_vpn2 = 19'(vpn2);
    wr_asid = 8'(asid); wr_lo0 = lo0; wr_lo1 = lo1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_lookup(input logic [31:0] va, input int asid, input int st,
                           output logic [63:0] res);
    @(negedge clk);
    lk_va = va; lk_asid = 8'(asid); lk_store = st[0];
    #1;
    res = {27'd0, lk_status, lk_attr, lk_pa};
  endtask

  task automatic do_probe(input int vpn2, input int asid);
    @(negedge clk);
    pr_en = 1'b1; pr_vpn2 = 19'(vpn2); pr_asid = 8'(asid);
    @(negedge clk);
    pr_en = 1'b0;
  endtask

  task automatic fill_slot(input int i);
    int glo1;
    e_n[i] = i % 7;
    e_vpn2[i] = i << 12;
    e_asid[i] = i + 1;
    e_pfn[i][0] = (i * 'h1357 + 'h100) & 'hFFFFF;
    e_pfn[i][1] = (i * 'h0AB1 + 'h80000) & 'hFFFFF;
    e_attr[i][0] = i % 8;
    e_attr[i][1] = (i + 3) % 8;
    e_d[i][0] = i % 2;
    e_v[i][0] = (i % 3 != 0) ? 1 : 0;
    e_d[i][1] = (i % 3 != 1) ? 1 : 0;
    e_v[i][1] = (i % 5 != 1) ? 1 : 0;
    // Slot 8: global bit only in the even word, so not global (R2).
    glo1 = (i % 4 == 0 && i != 8) ? 1 : 0;
    e_g[i] = glo1;
    do_write(i, 12'((1 << (2 * e_n[i])) - 1), e_vpn2[i], e_asid[i],
             mk_lo(e_pfn[i][0], e_attr[i][0], e_d[i][0], e_v[i][0], (i % 4 == 0) ? 1 : 0),
             mk_lo(e_pfn[i][1], e_attr[i][1], e_d[i][1], e_v[i][1], glo1));
  endtask

  task automatic check_read(input int i, input string req);
    @(negedge clk);
    rd_index = 4'(i);
    #1;
    check(req, "rd_mask", 64'(rd_mask), 64'((1 << (2 * e_n[i])) - 1));
    check(req, "rd_vpn2", 64'(rd_vpn2), 64'(e_vpn2[i]));
    check(req, "rd_asid", 64'(rd_asid), 64'(e_asid[i]));
    check(req, "rd_lo0", 64'(rd_lo0), 64'(mk_lo(e_pfn[i][0], e_attr[i][0], e_d[i][0], e_v[i][0], e_g[i])));
    check(req, "rd_lo1", 64'(rd_lo1), 64'(mk_lo(e_pfn[i][1], e_attr[i][1], e_d[i][1], e_v[i][1], e_g[i])));
  endtask

  initial begin
    logic [63:0] res;
    logic [31:0] va;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1", "ts", 64'(ts), 64'd0);
    check("R1", "mchk", 64'(mchk), 64'd0);
    check("R1", "pr_miss", 64'(pr_miss), 64'd0);
    check("R1", "pr_idx", 64'(pr_idx), 64'd0);
    do_lookup(32'h0000_0000, 0, 0, res);
    check("R1", "lookup of unwritten space", res, {27'd0, 2'd1, 3'd0, 32'd0});
    rd_index = 4'd3; #1;
    check("R1", "read of unwritten slot", 64'({rd_mask, rd_vpn2, rd_asid}), 64'd0);

    // Fill all slots; slot 0 tag 0 matches unwritten slots' zero tags (R9).
    for (int i = 0; i < 16; i++) begin
      fill_slot(i);
      check("R9", "mchk after fresh write", 64'(mchk), 64'd0);
    end
    check("R9", "ts after fill", 64'(ts), 64'd0);

    // R12 / R3 / R2: read back every slot
    for (int i = 0; i < 16; i++) check_read(i, "R12");

    // R2 R4 R5 R6: sweep slots, halves, load/store, own and foreign identifier
    for (int i = 0; i < 16; i++)
      for (int odd = 0; odd < 2; odd++)
        for (int st = 0; st < 2; st++)
          for (int am = 0; am < 2; am++) begin
            int asid = (am != 0) ? e_asid[i] : i + 100;
            va = mk_va(i, odd);
            do_lookup(va, asid, st, res);
            check("R4", $sformatf("lookup slot %0d odd %0d st %0d am %0d", i, odd, st, am),
                  res, exp_lookup(i, va, asid, st));
          end

    // R2: an unmasked tag bit differs (slot 7 has a 4K page)
    do_lookup((32'((7 << 12) | 1) << 13), 8, 0, res);
    check("R2", "unmasked tag mismatch", res, {27'd0, 2'd1, 3'd0, 32'd0});

    // R10: probe every slot, then a miss
    for (int i = 0; i < 16; i++) begin
      do_probe(e_vpn2[i], e_asid[i]);
      check("R10", $sformatf("probe slot %0d", i), 64'({pr_miss, pr_idx}), 64'(i));
    end
    do_probe('h7FFFF, 1);
    check("R10", "probe miss", 64'({pr_miss, pr_idx}), 64'h10);

    // R11: out-of-range writes, one a would-be duplicate
    do_write(16, 12'h000, 20 << 12, 1, mk_lo(1, 0, 1, 1, 0), mk_lo(2, 0, 1, 1, 0));
    check("R11", "mchk after index 16", 64'(mchk), 64'd0);
    do_write(31, 12'h000, 3 << 12, 4, mk_lo(1, 0, 1, 1, 0), mk_lo(2, 0, 1, 1, 0));
    check("R11", "mchk after index 31", 64'(mchk), 64'd0);
    check("R11", "ts after out-of-range", 64'(ts), 64'd0);
    do_lookup(32'(20 << 12) << 13, 1, 0, res);
    check("R11", "out-of-range tag absent", res, {27'd0, 2'd1, 3'd0, 32'd0});
    va = mk_va(3, 1);
    do_lookup(va, e_asid[3], 0, res);
    check("R11", "slot 3 unchanged", res, exp_lookup(3, va, e_asid[3], 0));

    // R9: rewrite slot 5 with its own tag
    e_pfn[5][0] = 'hABCDE; e_attr[5][0] = 2; e_d[5][0] = 1; e_v[5][0] = 1;
    e_pfn[5][1] = 'h12345; e_attr[5][1] = 3; e_d[5][1] = 0; e_v[5][1] = 1;
    do_write(5, 12'h3FF, e_vpn2[5], e_asid[5], mk_lo('hABCDE, 2, 1, 1, 0), mk_lo('h12345, 3, 0, 1, 0));
    check("R9", "self rewrite no mchk", 64'(mchk), 64'd0);
    check_read(5, "R9");
    for (int odd = 0; odd < 2; odd++) begin
      va = mk_va(5, odd);
      do_lookup(va, e_asid[5], 1, res);
      check("R6", $sformatf("rewritten slot 5 half %0d (uncached attr)", odd), res, exp_lookup(5, va, e_asid[5], 1));
    end

    // R3 / R2: slot 15 with a same-tag other-identifier entry and a pair-broken mask
    e_n[15] = 1; e_vpn2[15] = 2 << 12; e_asid[15] = 50; e_g[15] = 0;
    e_pfn[15][0] = 'h0F0F0; e_attr[15][0] = 5; e_d[15][0] = 1; e_v[15][0] = 1;
    e_pfn[15][1] = 'h0F0F1; e_attr[15][1] = 6; e_d[15][1] = 1; e_v[15][1] = 1;
    do_write(15, 12'h002, 2 << 12, 50, mk_lo('h0F0F0, 5, 1, 1, 0), mk_lo('h0F0F1, 6, 1, 1, 0));
    check("R2", "different identifier no mchk", 64'(mchk), 64'd0);
    check_read(15, "R3");
    for (int odd = 0; odd < 2; odd++) begin
      va = mk_va(15, odd);
      do_lookup(va, 50, 0, res);
      check("R3", $sformatf("slot 15 16K page half %0d", odd), res, exp_lookup(15, va, 50, 0));
    end
    va = mk_va(2, 1);
    do_lookup(va, 3, 0, res);
    check("R2", "slot 2 by own identifier", res, exp_lookup(2, va, 3, 0));

    // R7: duplicate within slot 6's 16M mask, same identifier
    do_write(9, 12'h000, (6 << 12) | 3, 7, mk_lo(1, 0, 1, 1, 0), mk_lo(2, 0, 1, 1, 0));
    check("R7", "mchk raised", 64'(mchk), 64'd1);
    check("R7", "ts raised", 64'(ts), 64'd1);
    rd_index = 4'd9; #1;
    check("R7", "aborted write left slot 9", 64'(rd_vpn2), 64'(e_vpn2[9]));
    @(negedge clk);
    check("R7", "mchk one cycle", 64'(mchk), 64'd0);
    check("R8", "ts sticky", 64'(ts), 64'd1);

    // R8: shutdown blocks lookup and probe, even after a fresh legal write
    va = mk_va(1, 0);
    do_lookup(va, e_asid[1], 0, res);
    check("R8", "lookup in shutdown", res, {27'd0, 2'd1, 3'd0, 32'd0});
    do_probe(e_vpn2[0], e_asid[0]);
    check("R8", "probe in shutdown", 64'({pr_miss, pr_idx}), 64'h10);
    do_write(10, 12'h000, 30 << 12, 1, mk_lo(7, 0, 1, 1, 0), mk_lo(8, 0, 1, 1, 0));
    do_lookup(32'(30 << 12) << 13, 1, 0, res);
    check("R8", "new write unmatched in shutdown", res, {27'd0, 2'd1, 3'd0, 32'd0});
    check("R8", "ts still set", 64'(ts), 64'd1);

    // R1: reset clears shutdown and every slot
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ts after reset", 64'(ts), 64'd0);
    do_lookup(mk_va(1, 0), e_asid[1], 0, res);
    check("R1", "lookup after reset", res, {27'd0, 2'd1, 3'd0, 32'd0});
    rd_index = 4'd1; #1;
    check("R1", "slot 1 cleared", 64'({rd_vpn2, rd_lo0}), 64'd0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule